// File: doc/BRIEF.md
# Symmetric-Tap Bit-Serial FIR Filter (Distributed Arithmetic)

This block is a linear-phase FIR filter of even length whose coefficients mirror about the centre. Samples enter one bit per clock, least-significant bit first, and a strobe marks the first bit of each sample. The block extends each sample by one sign bit on the fly and pushes it through a bit-serial delay line. Bit-serial adders with carry flip-flops sum each pair of taps that share a coefficient. This halves the number of terms, so a table of only 2^(TAPS/2) precomputed coefficient sums is needed. The table output drives a shift-accumulator that forms one full-precision parallel output sample for every input sample.

A register stage follows the pre-adders, and another follows the table. The accumulator's word timing is delayed by two cycles to match them. The caller supplies a strobe every FRAME = SAMPLE_W + 1 cycles. It then receives one output word with a one-cycle valid flag per sample period.

Top module: `fir_da_symm`

## Requirements
- R1: Each output equals the exact integer sum over i = 0..11 of h(i)·x(n−i), where x(n) is the sample whose strobe started the frame. The coefficients mirror, h(i) = h(11−i), with h(0..5) = 23, −41, 67, 112, −90, 250.
- R2: After reset, y is 0 and y_valid is 0. Samples received before the reset contribute zero to later outputs.
- R3: A sample is 8-bit two's complement, sent LSB first on din. word_start is high in the cycle of bit 0. Frames follow back to back with a period of 9 cycles. The value of din in the 9th cycle of a frame has no effect on any output.
- R4: y_valid is high for exactly one cycle per frame. It rises at the 10th rising edge after the edge that samples word_start, and y is updated at that same edge.
- R5: Between valid pulses, y holds its value.
- R6: Full-scale inputs (all samples −128, or all samples +127) give the exact result, with no overflow.
- R7: y_valid stays low after reset until the first word_start has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial sample bit, LSB first |
| word_start | input | 1 | High with bit 0 of each sample |
| y | output | 22 | Filter output, signed |
| y_valid | output | 1 | One-cycle flag for a new y |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:
- An impulse walks through all twelve taps. A mis-paired pre-adder or a wrong table entry then shows up as a wrong coefficient at one specific lag.
- Runs of −128 and +127 stress the sign-extension bit and the subtraction in the sign cycle. A design that drops the extra delay-line bit would wrap at these values.
- Junk is driven on the ninth bit of each frame. A design that used the live pin instead of its own sign copy would give a different result.
- A reset in mid-stream checks that the delay line is zero-filled. Stale samples would otherwise leak into the first outputs.
- Valid timing is compared on every cycle, so an off-by-one in the two-stage phase alignment cannot hide.

// File: rtl/fir_da_pkg.sv
package fir_da_pkg;

    localparam int P_TAPS     = 12;
    localparam int P_SAMPLE_W = 8;
    localparam int P_COEF_W   = 10;

    // per-cycle control that travels with the serial data
    typedef struct packed {
        logic vld;    // a frame is in progress
        logic first;  // bit 0 of the frame
        logic last;   // sign (extension) bit of the frame
    } tick_t;

    // distinct coefficients h(0) .. h(TAPS/2-1); the rest mirror
    function automatic int half_coef(input int j);
        case (j)
            0:       return 23;
            1:       return -41;
            2:       return 67;
            3:       return 112;
            4:       return -90;
            5:       return 250;
            default: return ((j * 37) % 200) - 100;
        endcase
    endfunction

    // table word: sum of the coefficients whose address bit is set
    function automatic int tbl_entry(input int addr, input int half);
        int s;
        s = 0;
        for (int j = 0; j < half; j++) begin
            if (((addr >> j) & 1) == 1) s += half_coef(j);
        end
        return s;
    endfunction

endpackage

// File: rtl/fir_da_delay_line.sv
module fir_da_delay_line #(
    parameter int TAPS  = 12,
    parameter int FRAME = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_in,
    output logic [TAPS-1:0] taps
);
    localparam int LINE   = (TAPS - 1) * FRAME;
    localparam int FILL_W = $clog2(LINE + 1);

    logic [LINE-1:0]   line_q;
    logic [FILL_W-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            fill_q <= '0;
        end else begin
            line_q <= {line_q[LINE-2:0], bit_in};
            if (fill_q < FILL_W'(LINE)) fill_q <= fill_q + 1'b1;
        end
    end

    assign taps[0] = bit_in;
    for (genvar k = 1; k < TAPS; k++) begin : g_tap
        assign taps[k] = line_q[k*FRAME-1];
    end

    // R2: until the line has been fully refilled, the oldest tap reads zero
    a_r2_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (fill_q < FILL_W'(LINE)) |-> !line_q[LINE-1]);

endmodule

// File: rtl/fir_da_preadd.sv
module fir_da_preadd (
    input  logic clk,
    input  logic rst,
    input  logic a,
    input  logic b,
    input  logic first,
    output logic sum_q
);
    logic carry_q;
    logic cin;

    assign cin = first ? 1'b0 : carry_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= 1'b0;
            sum_q   <= 1'b0;
        end else begin
            sum_q   <= a ^ b ^ cin;
            carry_q <= (a & b) | (cin & (a ^ b));
        end
    end

endmodule

// File: rtl/fir_da_coef_table.sv
module fir_da_coef_table #(
    parameter int HALF  = 6,
    parameter int TBL_W = 13
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [HALF-1:0]         addr,
    output logic signed [TBL_W-1:0] word_q
);
    localparam int DEPTH = 1 << HALF;

    logic signed [TBL_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = TBL_W'(fir_da_pkg::tbl_entry(g, HALF));
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= rom[addr];
    end

endmodule

// File: rtl/fir_da_shift_acc.sv
module fir_da_shift_acc
    import fir_da_pkg::*;
#(
    parameter int TBL_W = 13,
    parameter int FRAME = 9,
    parameter int OUT_W = TBL_W + FRAME
) (
    input  logic                    clk,
    input  logic                    rst,
    input  tick_t                   tk,
    input  logic signed [TBL_W-1:0] word,
    output logic signed [OUT_W-1:0] y,
    output logic                    y_valid
);
    localparam int GAP_W = $clog2(FRAME + 1);

    logic signed [OUT_W-1:0] acc_q, base, wext, addend, acc_n;

    always_comb begin
        base   = tk.first ? '0 : acc_q;
        wext   = {{(OUT_W-TBL_W){word[TBL_W-1]}}, word};
        addend = tk.last ? -wext : wext;
        acc_n  = (base >>> 1) + (addend <<< (FRAME - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            y       <= '0;
            y_valid <= 1'b0;
        end else begin
            y_valid <= 1'b0;
            if (tk.vld) begin
                acc_q <= acc_n;
                if (tk.last) begin
                    y       <= acc_n;
                    y_valid <= 1'b1;
                end
            end
        end
    end

    // spacing monitor for the valid flag
    logic [GAP_W-1:0] gap_q;
    logic             seen_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (y_valid) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else if (gap_q < GAP_W'(FRAME)) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        y_valid |=> !y_valid);

    a_r4_one_per_frame: assert property (@(posedge clk) disable iff (rst)
        (y_valid && seen_q) |-> (gap_q == GAP_W'(FRAME - 1)));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !y_valid |-> $stable(y));

endmodule

// File: rtl/fir_da_symm.sv
module fir_da_symm
    import fir_da_pkg::*;
#(
    parameter int TAPS     = P_TAPS,
    parameter int SAMPLE_W = P_SAMPLE_W,
    parameter int COEF_W   = P_COEF_W,
    localparam int HALF    = TAPS / 2,
    localparam int FRAME   = SAMPLE_W + 1,
    localparam int TBL_W   = COEF_W + $clog2(HALF),
    localparam int OUT_W   = TBL_W + FRAME
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    din,
    input  logic                    word_start,
    output logic signed [OUT_W-1:0] y,
    output logic                    y_valid
);
    localparam int PH_W = $clog2(FRAME);

    // ---------------- frame phase and sign extension ----------------
    logic [PH_W-1:0] ph_q, ph_cur;
    logic            started_q, live, ext_q, tap0;

    assign live   = word_start | started_q;
    assign ph_cur = word_start                      ? '0 :
                    (ph_q == PH_W'(FRAME - 1))      ? '0 : ph_q + 1'b1;
    assign tap0   = !live ? 1'b0 :
                    (ph_cur == PH_W'(SAMPLE_W)) ? ext_q : din;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= '0;
            started_q <= 1'b0;
            ext_q     <= 1'b0;
        end else begin
            ph_q      <= ph_cur;
            started_q <= live;
            if (ph_cur == PH_W'(SAMPLE_W - 1)) ext_q <= din;
        end
    end

    // R3: once running, a strobe may only arrive at a frame boundary
    a_r3_strobe_period: assert property (@(posedge clk) disable iff (rst)
        (word_start && started_q) |-> (ph_q == PH_W'(FRAME - 1)));

    // ---------------- control pipeline (matches the two data stages) ----------------
    tick_t t0, t1_q, t2_q;

    always_comb begin
        t0.vld   = live;
        t0.first = (ph_cur == '0);
        t0.last  = (ph_cur == PH_W'(FRAME - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t1_q <= '0;
            t2_q <= '0;
        end else begin
            t1_q <= t0;
            t2_q <= t1_q;
        end
    end

    // ---------------- delay line ----------------
    logic [TAPS-1:0] taps;

    fir_da_delay_line #(.TAPS(TAPS), .FRAME(FRAME)) u_line (
        .clk    (clk),
        .rst    (rst),
        .bit_in (tap0),
        .taps   (taps)
    );

    // ---------------- symmetric pre-adders (stage 1) ----------------
    logic [HALF-1:0] pair_sum;

    for (genvar j = 0; j < HALF; j++) begin : g_pair
        fir_da_preadd u_add (
            .clk   (clk),
            .rst   (rst),
            .a     (taps[j]),
            .b     (taps[TAPS-1-j]),
            .first (t0.first),
            .sum_q (pair_sum[j])
        );
    end

    // ---------------- coefficient-sum table (stage 2) ----------------
    logic signed [TBL_W-1:0] tbl_word;

    fir_da_coef_table #(.HALF(HALF), .TBL_W(TBL_W)) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .addr   (pair_sum),
        .word_q (tbl_word)
    );

    // ---------------- shift-accumulator ----------------
    fir_da_shift_acc #(.TBL_W(TBL_W), .FRAME(FRAME), .OUT_W(OUT_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .tk      (t2_q),
        .word    (tbl_word),
        .y       (y),
        .y_valid (y_valid)
    );

    // R7: nothing is produced before the first strobe has entered the pipe
    a_r7_no_early_valid: assert property (@(posedge clk) disable iff (rst)
        (!started_q && !t1_q.vld && !t2_q.vld) |=> !y_valid);

endmodule

// File: tb/sim_fir_da_symm.sv
`timescale 1ns/1ps
module sim_fir_da_symm;

    localparam int NT    = 12;
    localparam int FRM   = 9;
    localparam int LAT   = FRM + 1;   // edges from strobe edge to valid edge

    logic clk = 1'b0;
    logic rst, din, word_start;
    logic signed [21:0] y;
    logic y_valid;

    always #2 clk = ~clk;   // 250 MHz

    fir_da_symm u0 (
        .clk(clk), .rst(rst), .din(din), .word_start(word_start),
        .y(y), .y_valid(y_valid)
    );

    int hb [NT] = '{23, -41, 67, 112, -90, 250, 250, -90, 112, 67, -41, 23};
    int hist [$];
    int exp_due [$];
    int exp_val [$];
    string exp_tag [$];
    int nchk = 0, nbad = 0;
    int cyc = 0;
    bit chk_on = 0;
    bit done = 0;
    bit ev;
    logic signed [21:0] held;
    string tag;
    int seed = 7;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic fail(input string req, input int got, input int expv);
        nbad++;
        $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, got, expv, cyc);
    endtask

    task automatic clear_hist();
        hist.delete();
        for (int i = 0; i < NT; i++) hist.push_back(0);
        exp_due.delete(); exp_val.delete(); exp_tag.delete();
    endtask

    function automatic int ref_y();
        int s = 0;
        for (int i = 0; i < NT; i++) s += hb[i] * hist[i];
        return s;
    endfunction

    // send one sample frame; junk goes on the ninth (ignored) bit
    task automatic send(input int s, input bit junk);
        logic [7:0] v;
        v = 8'(s);
        for (int b = 0; b < FRM; b++) begin
            @(negedge clk);
            word_start = (b == 0);
            din = (b < 8) ? v[b] : junk;
            if (b == 0) begin
                hist.push_front(s);
                void'(hist.pop_back());
                exp_due.push_back(cyc + 1 + LAT);
                exp_val.push_back(ref_y());
                exp_tag.push_back(tag);
            end
        end
    endtask

    function automatic int lcg();
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 16) & 255) - 128;
    endfunction

    // cycle-by-cycle comparison against the reference queue
    always @(negedge clk) begin
        if (chk_on) begin
            ev = (exp_due.size() > 0) && (exp_due[0] == cyc);
            nchk++;
            if (y_valid !== ev) fail("R4 valid", int'(y_valid), int'(ev));
            if (ev) begin
                nchk++;
                if (int'(y) != exp_val[0]) fail(exp_tag[0], int'(y), exp_val[0]);
                held = y;
                void'(exp_due.pop_front()); void'(exp_val.pop_front());
                void'(exp_tag.pop_front());
            end else if (!y_valid) begin
                nchk++;
                if (y !== held) fail("R5 hold", int'(y), int'(held));
            end
        end
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", nchk, nbad);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; din = 1'b0; word_start = 1'b0;
        held = '0;
        tag = "R1";
        clear_hist();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R2: reset state
        nchk++; if (y !== 0) fail("R2 reset y", int'(y), 0);
        nchk++; if (y_valid !== 1'b0) fail("R2 reset valid", int'(y_valid), 0);

        // R7: idle after reset produces no valid
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            nchk++; if (y_valid !== 1'b0) fail("R7 early valid", int'(y_valid), 0);
        end

        chk_on = 1'b1;
        // R1: impulse walks through every tap
        tag = "R1 impulse";
        send(1, 1'b0);
        for (int i = 0; i < NT; i++) send(0, 1'b0);
        // R6: full-scale extremes
        tag = "R6 min";
        for (int i = 0; i < NT + 2; i++) send(-128, 1'b0);
        tag = "R6 max";
        for (int i = 0; i < NT + 2; i++) send(127, 1'b0);
        // R3: ninth bit forced opposite to the sign bit
        tag = "R3 junk bit";
        for (int i = 0; i < 16; i++) begin
            int s = lcg();
            send(s, (s >= 0));
        end
        // R1: general random data with random ninth bit
        tag = "R1 random";
        for (int i = 0; i < 30; i++) send(lcg(), lcg() > 0);
        repeat (6) @(negedge clk);
        chk_on = 1'b0;
        nchk++; if (exp_due.size() != 0) fail("R4 missing outputs", exp_due.size(), 0);

        // R2: reset mid-stream, history must be zero-filled
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        word_start = 1'b0;
        clear_hist();
        held = '0;
        nchk++; if (y !== 0) fail("R2 mid reset y", int'(y), 0);
        chk_on = 1'b1;
        tag = "R2 zero fill";
        for (int i = 0; i < 5; i++) send(100 - 37 * i, 1'b1);
        repeat (6) @(negedge clk);
        chk_on = 1'b0;
        nchk++; if (exp_due.size() != 0) fail("R2 missing outputs", exp_due.size(), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule